// File: doc/BRIEF.md
# Word-Aligned Hybrid Bitmap Encoder

This block packs an uncompressed bit vector into a stream of 64-bit hybrid atoms. The vector arrives as 63-bit chunks on a valid/ready stream that carries an end-of-vector flag. Any chunk that holds both zeros and ones is passed through as a literal atom. A chunk of all zeros or all ones is folded into a running fill. The fill counts whole chunks, not bits, and goes out as one atom when the run ends.

The encoder keeps at most one open fill in its state. When that fill has to be closed at the same moment a new atom is produced, it keeps one extra atom in a holding slot, so the output order always follows the input order. The final input chunk flushes any open fill, and the last output atom of the vector carries the output end flag. A run that reaches the configured length limit is closed, and a new fill of the same value starts with the next chunk.

Top module: `wah_encoder`

## Requirements
- R1: A chunk that is neither all zeros nor all ones produces an atom with bit 63 clear and bits 62:0 equal to the chunk.
- R2: A fill atom has bit 63 set, bit 62 equal to the run value (1 for all ones), and bits 61:0 equal to the number of chunks in the run, which is never zero.
- R3: Consecutive uniform chunks of the same value merge into a single fill atom whose length is their count.
- R4: A uniform chunk whose value differs from the open fill's value closes that fill and starts a new run.
- R5: A literal chunk that arrives while a fill is open makes the fill atom come out first and the literal atom right after it.
- R6: The chunk that carries the input end flag flushes any open fill, and only the final atom produced for that vector carries the output end flag.
- R7: When a run reaches RUN_MAX chunks, the fill is emitted with length RUN_MAX and the next uniform chunk of the same value starts a new fill.
- R8: A single uniform chunk followed by a different chunk is emitted as a fill of length 1, never as a literal.
- R9: While out_valid is high and out_ready is low, out_atom and out_last stay unchanged and out_valid stays high.
- R10: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input chunk is valid |
| in_ready | output | 1 | Encoder accepts a chunk on this cycle |
| in_chunk | input | 63 | Uncompressed chunk of the bit vector |
| in_last | input | 1 | Chunk is the final one of the vector |
| out_valid | output | 1 | Output atom is valid |
| out_ready | input | 1 | Consumer accepts the atom |
| out_atom | output | 64 | Encoded literal or fill atom |
| out_last | output | 1 | Atom is the final one of the vector |

## Verification
The assertions check the atom-level invariants on every cycle: no fill of length zero or above the limit, no literal that holds a uniform chunk, outputs that stay stable while the consumer stalls, and an idle reset state. Merging, closing a run on a value change, ordering a fill ahead of a literal, splitting at saturation and the end-of-vector flush all depend on the history of chunks. Only the bench's scenarios can show these. Its reference model predicts the exact atom sequence from the chunks it accepts, and the bench compares that sequence against the output under both free-flowing and stalled consumers.

// File: rtl/wah_encoder.sv
module wah_encoder #(
  parameter logic [61:0] RUN_MAX = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [62:0] in_chunk,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_atom,
  output logic        out_last
);
  localparam int CW = 63;
  localparam int LW = 62;
  localparam int AW = CW + 1;

  logic          pend_v, pend_val;
  logic [LW-1:0] pend_len;
  logic          hold_v, hold_l;
  logic [AW-1:0] hold_d;

  logic          fire, is_zero, is_one, uni, ext, flush;
  logic          new_v, new_l;
  logic [AW-1:0] new_d, pend_atom;
  logic          a_v, a_l, b_v, b_l;
  logic [AW-1:0] a_d, b_d;
  logic [LW-1:0] run_len;

  assign in_ready  = !hold_v && (!out_valid || out_ready);
  assign fire      = in_valid && in_ready;
  assign is_zero   = (in_chunk == '0);
  assign is_one    = (&in_chunk);
  assign uni       = is_zero || is_one;
  assign ext       = pend_v && uni && (pend_val == is_one) && (pend_len != RUN_MAX);
  assign flush     = pend_v && !ext;
  assign run_len   = ext ? pend_len + LW'(1) : LW'(1);
  assign pend_atom = {1'b1, pend_val, pend_len};

  always_comb begin
    new_v = 1'b0;
    new_d = '0;
    new_l = in_last;
    if (!uni) begin
      new_v = 1'b1;
      new_d = {1'b0, in_chunk};
    end else if (in_last) begin
      new_v = 1'b1;
      new_d = {1'b1, is_one, run_len};
    end
  end

  always_comb begin
    if (flush) begin
      a_v = 1'b1;  a_d = pend_atom; a_l = 1'b0;
      b_v = new_v; b_d = new_d;     b_l = new_l;
    end else begin
      a_v = new_v; a_d = new_d;     a_l = new_l;
      b_v = 1'b0;  b_d = '0;        b_l = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_val  <= 1'b0;
      pend_len  <= '0;
      out_valid <= 1'b0;
      out_atom  <= '0;
      out_last  <= 1'b0;
      hold_v    <= 1'b0;
      hold_d    <= '0;
      hold_l    <= 1'b0;
    end else if (fire) begin
      pend_v    <= uni && !in_last;
      pend_val  <= is_one;
      pend_len  <= run_len;
      out_valid <= a_v;
      out_atom  <= a_d;
      out_last  <= a_l;
      hold_v    <= b_v;
      hold_d    <= b_d;
      hold_l    <= b_l;
    end else if (out_valid && out_ready) begin
      out_valid <= hold_v;
      out_atom  <= hold_d;
      out_last  <= hold_l;
      hold_v    <= 1'b0;
    end
  end
endmodule

// File: rtl/wah_encoder_chk.sv
module wah_encoder_chk #(
  parameter logic [61:0] RUN_MAX = '1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_atom,
  input logic        out_last
);
  // R2
  fill_len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_atom[63] |-> out_atom[61:0] != '0);

  // R7
  fill_len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_atom[63] |-> out_atom[61:0] <= RUN_MAX);

  // R1
  literal_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_atom[63] |-> (out_atom[62:0] != '0) && !(&out_atom[62:0]));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_atom) && $stable(out_last));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid && in_ready);
endmodule

bind wah_encoder wah_encoder_chk #(.RUN_MAX(RUN_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_atom(out_atom), .out_last(out_last)
);

// File: tb/wah_encoder_bench.sv
module wah_encoder_bench;
  localparam logic [61:0] RMAX = 62'd3;
  localparam logic [62:0] ZERO = '0;
  localparam logic [62:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [62:0] in_chunk = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_atom;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;
  bit mon_on = 1'b0;

  logic [64:0] expq[$];
  string       tagq[$];
  bit          m_pv = 1'b0;
  bit          m_val = 1'b0;
  longint      m_len = 0;

  always #2 clk = ~clk;

  wah_encoder #(.RUN_MAX(RMAX)) u_wah_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chunk(in_chunk), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_atom(out_atom), .out_last(out_last)
  );

  task automatic push(input bit is_fill, input bit v, input longint len,
                      input logic [62:0] lit, input bit last, input string tag);
    if (is_fill) expq.push_back({last, 1'b1, v, len[61:0]});
    else         expq.push_back({last, 1'b0, lit});
    tagq.push_back(tag);
  endtask

  task automatic model(input logic [62:0] c, input bit last);
    bit u, v;
    u = (c == ZERO) || (c == ONES);
    v = (c == ONES);
    if (m_pv && u && m_val == v && m_len < longint'(RMAX)) begin
      m_len++;
      if (last) begin
        push(1, v, m_len, '0, 1, "R6");
        m_pv = 0;
      end
    end else begin
      if (m_pv)
        push(1, m_val, m_len, '0, 0,
             !u ? "R5" : (m_len == 1 ? "R8" : (m_val != v ? "R4" : "R7")));
      if (!u) begin
        push(0, 0, 0, c, last, "R1");
        m_pv = 0;
      end else if (last) begin
        push(1, v, 1, '0, 1, "R2");
        m_pv = 0;
      end else begin
        m_pv = 1; m_val = v; m_len = 1;
      end
    end
  endtask

  task automatic send(input logic [62:0] c, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_chunk = c;
    in_last  = last;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    model(c, last);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [64:0] act,
                       input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // consumer and comparison against the model
  initial begin
    int cyc = 0;
    bit was_stall = 0;
    logic [64:0] held = '0;
    logic [64:0] e;
    string t;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
      #2;
      if (mon_on) begin
        if (was_stall) begin
          check(out_valid && {out_last, out_atom} == held, "R9",
                {out_last, out_atom}, held);
        end
        was_stall = out_valid && !out_ready;
        held = {out_last, out_atom};
        if (out_valid && out_ready) begin
          if (expq.size() == 0) begin
            check(0, "unexpected atom", {out_last, out_atom}, '0);
          end else begin
            e = expq.pop_front();
            t = tagq.pop_front();
            check({out_last, out_atom} == e, t, {out_last, out_atom}, e);
          end
        end
      end
    end
  end

  initial begin
    int n = 0;
    while (n < 100000) begin
      @(posedge clk);
      n++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic drain();
    int k = 0;
    while ((expq.size() != 0 || out_valid) && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check(expq.size() == 0, "drain", 65'(expq.size()), '0);
  endtask

  initial begin
    logic [62:0] lf = 63'h1234_5678_9ABC_DEF1;
    repeat (2) @(negedge clk);
    #1;
    // R10
    check(!out_valid, "R10", {64'd0, out_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid && in_ready, "R10", {63'd0, out_valid, in_ready}, 65'd1);
    mon_on = 1'b1;

    // R1: lone literal
    send(63'h5A5A_0000_FFFF_1234, 1);
    drain();
    // R3/R6: two zero chunks -> fill 0 len 2
    send(ZERO, 0); send(ZERO, 1);
    drain();
    // R4/R5/R8: zeros, ones, literal, ones
    send(ZERO, 0); send(ONES, 0); send(63'h0F0F, 0); send(ONES, 1);
    drain();
    // R7: seven ones with limit 3 -> 3,3,1
    for (int i = 0; i < 7; i++) send(ONES, i == 6);
    drain();
    // R7 then value change, R5 after saturation
    for (int i = 0; i < 3; i++) send(ZERO, 0);
    send(ZERO, 0); send(63'h1, 0); send(ONES, 0); send(ONES, 0); send(ZERO, 1);
    drain();

    // mixed sequence with and without stalls
    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      for (int i = 0; i < 80; i++) begin
        lf = {lf[61:0], lf[62] ^ lf[61] ^ lf[0]};
        case (lf[5:3])
          3'd0, 3'd1, 3'd2: send(ZERO, i == 79);
          3'd3, 3'd4:       send(ONES, i == 79);
          default:          send((lf == ZERO || lf == ONES) ? 63'h2 : lf, i == 79);
        endcase
      end
      drain();
    end
    stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule